// File: doc/BRIEF.md
# ADC Power Sequencing Controller

This block brings an on-chip ADC's analog supply out of power-down in a safe order and keeps conversions from starting until the analog reference has settled. A power-on request first enables the bandgap and the reference together. The block then waits a programmable bandgap settling interval and enables the converter core. After a second programmable interval it raises a ready flag. A power-off request clears all three enables in a single cycle from any state, which also cancels a sequence that is still in progress.

Settling intervals are given in microseconds. A prescaler derives a one-microsecond tick from the free-running clock using a programmable cycles-per-microsecond value. The three enables are presented as bits of an 8-bit control word, and the analog macro decodes them at fixed positions.

Conversion requests use a valid-only stream with no back-pressure. Each cycle with `conv_req_valid` high consumes one request. When the block is ready, the request is forwarded as a one-cycle `conv_start` on the next cycle. Otherwise it is dropped and `conv_err` pulses for one cycle instead. A request is never held or queued, so an upstream source must retry after `adc_ready` rises.

Top module: `adc_pwr_seq`

## Requirements
- R1: While reset is high and on the cycle after it, the control word is 0x00, `adc_ready` is 0, and `conv_start` and `conv_err` are 0. Control word bits 4..0 are always 0.
- R2: A power-on request in the off state sets bit 6 (bandgap enable) and bit 5 (reference enable) on the next clock edge. Bit 7 (core enable) stays 0 at that point.
- R3: Bit 7 rises exactly BG_US × CPU clock cycles after bits 6 and 5 rise. BG_US is the bandgap wait in microseconds and CPU is the cycles-per-microsecond value. Bit 7 is never 1 unless bits 6 and 5 are also 1.
- R4: `adc_ready` rises exactly CORE_US × CPU cycles after bit 7 rises.
- R5: `adc_ready` is 1 only while all three enables are 1. A request with `conv_req_valid` high while ready produces `conv_start` = 1 for exactly the following cycle, with `conv_err` = 0.
- R6: A request while not ready produces `conv_err` = 1 for exactly the following cycle and no `conv_start`.
- R7: A power-off request in any state clears control word bits 7..5 and `adc_ready` on the next edge. Power-off takes precedence over a simultaneous power-on.
- R8: A power-on request during either wait, or while ready, is ignored and does not change the timing of the sequence.
- R9: A configuration write is accepted only in the off state and is ignored in any other state. A written value of 0 for any of the three settings behaves as 1.
- R10: After reset, the waits are 8000 µs and 50 µs and the prescaler holds the parameter DEF_CYC_PER_US.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on_req | input | 1 | Start the power-up sequence |
| pwr_off_req | input | 1 | Clear all enables and return to off |
| cfg_wr | input | 1 | Load the three settings below (only in off) |
| cfg_cyc_per_us | input | PRESC_W (8) | Clock cycles per microsecond |
| cfg_bg_us | input | US_W (14) | Bandgap settling wait in µs |
| cfg_core_us | input | US_W (14) | Core settling wait in µs |
| conv_req_valid | input | 1 | Conversion start request |
| ctrl_word | output | 8 | Bit 7 core, bit 6 bandgap, bit 5 reference enable |
| adc_ready | output | 1 | Both waits finished, conversions allowed |
| conv_start | output | 1 | Forwarded conversion start pulse |
| conv_err | output | 1 | Pulse for a request dropped while not ready |

## Verification
The assertions check the invariants that hold on every cycle:
- the core enable never appears without the bandgap and reference enables, and only rises when they were already on;
- ready implies all three enables;
- power-off empties the control word on the next edge;
- a forwarded start or an error pulse matches the ready flag of the previous cycle.

Only the bench's scenarios can show the exact settling durations. It sweeps prescaler and wait settings and compares against products computed arithmetically. The scenarios also cover the reset defaults, aborts in each wait, the ignored repeat power-on, the rejected configuration write outside off, and the treatment of zero settings.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

  typedef enum logic [1:0] {
    ST_OFF      = 2'd0,
    ST_BG_WAIT  = 2'd1,
    ST_PWD_WAIT = 2'd2,
    ST_READY    = 2'd3
  } pwr_state_t;

  localparam int CTRL_W      = 8;
  localparam int BIT_REF_EN  = 5;
  localparam int BIT_BG_EN   = 6;
  localparam int BIT_CORE_EN = 7;

endpackage

// File: rtl/adc_pwr_cfg.sv
module adc_pwr_cfg #(
  parameter int PRESC_W        = 8,
  parameter int US_W           = 14,
  parameter int DEF_CYC_PER_US = 250,
  parameter int DEF_BG_US      = 8000,
  parameter int DEF_CORE_US    = 50
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               is_off,
  input  logic [PRESC_W-1:0] wr_cyc_per_us,
  input  logic [US_W-1:0]    wr_bg_us,
  input  logic [US_W-1:0]    wr_core_us,
  output logic [PRESC_W-1:0] cyc_per_us,
  output logic [US_W-1:0]    bg_us,
  output logic [US_W-1:0]    core_us
);
  localparam logic [PRESC_W-1:0] RST_PRESC = PRESC_W'(DEF_CYC_PER_US);
  localparam logic [US_W-1:0]    RST_BG    = US_W'(DEF_BG_US);
  localparam logic [US_W-1:0]    RST_CORE  = US_W'(DEF_CORE_US);

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_per_us <= RST_PRESC;
      bg_us      <= RST_BG;
      core_us    <= RST_CORE;
    end else if (wr_en && is_off) begin
      cyc_per_us <= wr_cyc_per_us;
      bg_us      <= wr_bg_us;
      core_us    <= wr_core_us;
    end
  end
endmodule

// File: rtl/adc_pwr_timer.sv
module adc_pwr_timer #(
  parameter int PRESC_W = 8,
  parameter int US_W    = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               abort,
  input  logic [US_W-1:0]    load_us,
  input  logic [PRESC_W-1:0] cyc_per_us,
  output logic               done
);
  logic [PRESC_W-1:0] presc_cnt;
  logic [US_W-1:0]    us_left;
  logic               running;
  logic [PRESC_W-1:0] presc_eff;
  logic [US_W-1:0]    us_eff;
  logic               us_tick;

  assign presc_eff = (cyc_per_us == '0) ? PRESC_W'(1) : cyc_per_us;
  assign us_eff    = (load_us == '0) ? US_W'(1) : load_us;
  assign us_tick   = running && (presc_cnt == presc_eff - PRESC_W'(1));
  assign done      = us_tick && (us_left == US_W'(1));

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      running   <= 1'b0;
      presc_cnt <= '0;
      us_left   <= '0;
    end else if (load) begin
      running   <= 1'b1;
      presc_cnt <= '0;
      us_left   <= us_eff;
    end else if (running) begin
      if (us_tick) begin
        presc_cnt <= '0;
        if (us_left == US_W'(1)) running <= 1'b0;
        else                     us_left <= us_left - US_W'(1);
      end else begin
        presc_cnt <= presc_cnt + PRESC_W'(1);
      end
    end
  end
endmodule

// File: rtl/adc_pwr_fsm.sv
module adc_pwr_fsm
  import adc_pwr_pkg::*;
#(
  parameter int US_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_on,
  input  logic              pwr_off,
  input  logic              wait_done,
  input  logic [US_W-1:0]   bg_us,
  input  logic [US_W-1:0]   core_us,
  output logic              tmr_load,
  output logic              tmr_abort,
  output logic [US_W-1:0]   tmr_us,
  output logic              is_off,
  output logic [CTRL_W-1:0] ctrl,
  output logic              ready
);
  pwr_state_t state, state_nx;

  always_comb begin
    state_nx  = state;
    tmr_load  = 1'b0;
    tmr_abort = 1'b0;
    tmr_us    = bg_us;
    if (pwr_off) begin
      state_nx  = ST_OFF;
      tmr_abort = 1'b1;
    end else begin
      unique case (state)
        ST_OFF: if (pwr_on) begin
          state_nx = ST_BG_WAIT;
          tmr_load = 1'b1;
          tmr_us   = bg_us;
        end
        ST_BG_WAIT: if (wait_done) begin
          state_nx = ST_PWD_WAIT;
          tmr_load = 1'b1;
          tmr_us   = core_us;
        end
        ST_PWD_WAIT: if (wait_done) state_nx = ST_READY;
        ST_READY:    state_nx = ST_READY;
        default:     state_nx = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_OFF;
    else     state <= state_nx;
  end

  logic bg_on, core_on;
  assign bg_on   = (state != ST_OFF);
  assign core_on = (state == ST_PWD_WAIT) || (state == ST_READY);
  assign ready   = (state == ST_READY);
  assign is_off  = (state == ST_OFF);

  for (genvar b = 0; b < CTRL_W; b++) begin : g_ctrl
    if (b == BIT_CORE_EN) begin : g_core
      assign ctrl[b] = core_on;
    end else if (b == BIT_BG_EN || b == BIT_REF_EN) begin : g_bg
      assign ctrl[b] = bg_on;
    end else begin : g_zero
      assign ctrl[b] = 1'b0;
    end
  end
endmodule

// File: rtl/adc_pwr_gate.sv
module adc_pwr_gate (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic ready,
  output logic start,
  output logic err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      start <= 1'b0;
      err   <= 1'b0;
    end else begin
      start <= req_valid && ready;
      err   <= req_valid && !ready;
    end
  end
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_pkg::*;
#(
  parameter int PRESC_W        = 8,
  parameter int US_W           = 14,
  parameter int DEF_CYC_PER_US = 250,
  parameter int DEF_BG_US      = 8000,
  parameter int DEF_CORE_US    = 50
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwr_on_req,
  input  logic               pwr_off_req,
  input  logic               cfg_wr,
  input  logic [PRESC_W-1:0] cfg_cyc_per_us,
  input  logic [US_W-1:0]    cfg_bg_us,
  input  logic [US_W-1:0]    cfg_core_us,
  input  logic               conv_req_valid,
  output logic [7:0]         ctrl_word,
  output logic               adc_ready,
  output logic               conv_start,
  output logic               conv_err
);
  logic [PRESC_W-1:0] cur_presc;
  logic [US_W-1:0]    cur_bg, cur_core, tmr_us;
  logic               tmr_load, tmr_abort, tmr_done, is_off;

  adc_pwr_cfg #(
    .PRESC_W(PRESC_W), .US_W(US_W), .DEF_CYC_PER_US(DEF_CYC_PER_US),
    .DEF_BG_US(DEF_BG_US), .DEF_CORE_US(DEF_CORE_US)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .is_off(is_off),
    .wr_cyc_per_us(cfg_cyc_per_us), .wr_bg_us(cfg_bg_us), .wr_core_us(cfg_core_us),
    .cyc_per_us(cur_presc), .bg_us(cur_bg), .core_us(cur_core)
  );

  adc_pwr_timer #(.PRESC_W(PRESC_W), .US_W(US_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .abort(tmr_abort),
    .load_us(tmr_us), .cyc_per_us(cur_presc), .done(tmr_done)
  );

  adc_pwr_fsm #(.US_W(US_W)) u_fsm (
    .clk(clk), .rst(rst), .pwr_on(pwr_on_req), .pwr_off(pwr_off_req),
    .wait_done(tmr_done), .bg_us(cur_bg), .core_us(cur_core),
    .tmr_load(tmr_load), .tmr_abort(tmr_abort), .tmr_us(tmr_us),
    .is_off(is_off), .ctrl(ctrl_word), .ready(adc_ready)
  );

  adc_pwr_gate u_gate (
    .clk(clk), .rst(rst), .req_valid(conv_req_valid), .ready(adc_ready),
    .start(conv_start), .err(conv_err)
  );
endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       pwr_off_req,
  input logic [7:0] ctrl_word,
  input logic       adc_ready,
  input logic       conv_start,
  input logic       conv_err
);
  a_r3_core_needs_bg: assert property (@(posedge clk) disable iff (rst)
    ctrl_word[7] |-> (ctrl_word[6] && ctrl_word[5]));

  a_r3_core_after_bg: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_word[7]) |-> $past(ctrl_word[6]));

  a_r1_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    ctrl_word[4:0] == 5'b0);

  a_r5_ready_all_on: assert property (@(posedge clk) disable iff (rst)
    adc_ready |-> (ctrl_word[7:5] == 3'b111));

  a_r7_off_clears: assert property (@(posedge clk) disable iff (rst)
    pwr_off_req |=> (ctrl_word[7:5] == 3'b000 && !adc_ready));

  a_r5_start_when_ready: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> $past(adc_ready));

  a_r6_err_when_not_ready: assert property (@(posedge clk) disable iff (rst)
    conv_err |-> !$past(adc_ready));

  a_r6_start_err_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(conv_start && conv_err));
endmodule

bind adc_pwr_seq adc_pwr_seq_chk u_chk (
  .clk(clk), .rst(rst), .pwr_off_req(pwr_off_req), .ctrl_word(ctrl_word),
  .adc_ready(adc_ready), .conv_start(conv_start), .conv_err(conv_err)
);

// File: tb/adc_pwr_seq_test.sv
module adc_pwr_seq_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1;
  logic       pwr_on_req = 1'b0, pwr_off_req = 1'b0, cfg_wr = 1'b0, conv_req_valid = 1'b0;
  logic [7:0] cfg_cyc_per_us = '0;
  logic [13:0] cfg_bg_us = '0, cfg_core_us = '0;
  logic [7:0] ctrl_word;
  logic       adc_ready, conv_start, conv_err;

  adc_pwr_seq #(.DEF_CYC_PER_US(1)) uut (
    .clk(clk), .rst(rst), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
    .cfg_wr(cfg_wr), .cfg_cyc_per_us(cfg_cyc_per_us), .cfg_bg_us(cfg_bg_us),
    .cfg_core_us(cfg_core_us), .conv_req_valid(conv_req_valid),
    .ctrl_word(ctrl_word), .adc_ready(adc_ready), .conv_start(conv_start),
    .conv_err(conv_err)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(int p, int b, int c);
    cfg_wr = 1'b1; cfg_cyc_per_us = 8'(p); cfg_bg_us = 14'(b); cfg_core_us = 14'(c);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic power_off();
    pwr_off_req = 1'b1;
    @(negedge clk);
    pwr_off_req = 1'b0;
    chk("R7 off ctrl", {24'd0, ctrl_word}, 32'h00);
    chk("R7 off ready", {31'd0, adc_ready}, 0);
  endtask

  // Power on and follow every cycle; tbg/tcore are expected cycle counts.
  task automatic run_seq(string tag, int tbg, int tcore, bit inject_on);
    pwr_on_req = 1'b1;
    @(negedge clk);
    pwr_on_req = 1'b0;
    chk({tag, " R2 first"}, {24'd0, ctrl_word}, 32'h60);
    for (int i = 0; i <= tbg + tcore + 1; i++) begin
      chk({tag, " R3 ctrl"}, {24'd0, ctrl_word}, (i >= tbg) ? 32'hE0 : 32'h60);
      chk({tag, " R4 ready"}, {31'd0, adc_ready}, (i >= tbg + tcore) ? 1 : 0);
      pwr_on_req = (inject_on && (i == 1 || i == tbg + 1)) ? 1'b1 : 1'b0; // R8
      @(negedge clk);
    end
    pwr_on_req = 1'b0;
  endtask

  task automatic conv_probe(bit exp_ok, string tag);
    conv_req_valid = 1'b1;
    @(negedge clk);
    conv_req_valid = 1'b0;
    chk({tag, " start"}, {31'd0, conv_start}, exp_ok ? 1 : 0);
    chk({tag, " err"}, {31'd0, conv_err}, exp_ok ? 0 : 1);
    @(negedge clk);
    chk({tag, " pulse end"}, {30'd0, conv_start, conv_err}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ctrl", {24'd0, ctrl_word}, 0);
    chk("R1 reset ready", {29'd0, adc_ready, conv_start, conv_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {24'd0, ctrl_word}, 0);

    conv_probe(0, "R6 off");

    run_seq("R10 defaults", 8000, 50, 0);
    conv_probe(1, "R5 ready");
    power_off();

    for (int p = 1; p <= 3; p++)
      for (int b = 1; b <= 3; b++)
        for (int c = 1; c <= 2; c++) begin
          write_cfg(p, b, c);
          run_seq("sweep", b * p, c * p, p == 2);
          conv_probe(1, "R5 sweep");
          power_off();
        end

    // Aborts during each wait (R7), request in a wait (R6)
    write_cfg(2, 3, 2);
    pwr_on_req = 1'b1; @(negedge clk); pwr_on_req = 1'b0;
    conv_probe(0, "R6 bgwait");
    power_off();
    pwr_on_req = 1'b1; @(negedge clk); pwr_on_req = 1'b0;
    repeat (7) @(negedge clk);
    chk("R7 in core wait", {24'd0, ctrl_word}, 32'hE0);
    conv_probe(0, "R6 corewait");
    power_off();
    run_seq("R7 restart", 6, 4, 0);
    power_off();

    // Off wins over a simultaneous on
    pwr_on_req = 1'b1; pwr_off_req = 1'b1;
    @(negedge clk);
    pwr_on_req = 1'b0; pwr_off_req = 1'b0;
    @(negedge clk);
    chk("R7 off wins", {24'd0, ctrl_word}, 0);

    // Zero settings behave as one
    write_cfg(0, 0, 0);
    run_seq("R9 zero", 1, 1, 0);
    // Write while ready is ignored
    write_cfg(3, 3, 3);
    power_off();
    run_seq("R9 ignored write", 1, 1, 0);
    power_off();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule